// File: doc/BRIEF.md
# Low-Power Wakeup Sequencer

This block handles entry into and exit from sleep for a small microcontroller. A sleep command from the CPU makes the sequencer take the bus with a request. Power-down is raised only after the CPU has granted that request. While the system is asleep, the sequencer watches the interrupt request vector through its mask. Only an unmasked pending request ends sleep, and it does so whether or not the CPU has interrupts globally enabled. The CPU is free to ignore that interrupt after it wakes.

Wakeup is timed by the slow 32 kHz clock and uses both of its edges. The request is sampled twice on falling edges. The next rising edge releases power-down, so the flash, oscillator and reference circuits can come back up. The rising edge after that latches the power-on-reset and low-voltage monitor levels, because they have settled by then, and raises a one-cycle strobe. The falling edge after the sampling step drops the bus request. On the CPU clock side, the request passes through a two-flop synchronizer before the acknowledge follows it. Once the acknowledge has fallen and has been brought back into the slow domain, the sequencer reports itself awake.

Top module: `wake_seq_top`

## Requirements
- R1: While reset is high and right after it, pwr_down, bus_req, bus_ack, asleep, smp_stb, por_lat and lvd_lat are all 0.
- R2: A one-cycle sleep_req pulse sets asleep and bus_req. bus_ack follows bus_req through a two-flop CPU-clock synchronizer plus one register. pwr_down rises only while bus_ack is 1, and never in the same sampled cycle that asleep first shows 1.
- R3: While asleep, any bit i with irq_pend[i]=1 and irq_mask[i]=0 starts a wakeup. A mask bit of 1 blocks its request. No global enable input exists.
- R4: While asleep, pending requests whose mask bits are all 1 leave pwr_down and bus_req at 1, for every such pend/mask combination.
- R5: A qualifying request present before a slow falling edge is sampled on that edge and on the next falling edge. pwr_down falls on the first slow rising edge after the second sample.
- R6: On the next slow rising edge, por_in and lvd_in are latched into por_lat and lvd_lat, and smp_stb is 1 for exactly one slow cycle.
- R7: bus_req falls on the slow falling edge that follows the sampling rising edge.
- R8: bus_ack falls on the third CPU rising edge after bus_req falls. asleep clears on the second slow rising edge after bus_ack has fallen and been resynchronized.
- R9: A request that arrives while the block is awake has no effect: asleep, pwr_down, bus_req and smp_stb stay 0.
- R10: por_lat and lvd_lat hold their values until the next sampling step, whatever por_in and lvd_in do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 32 kHz sequencing clock (both edges used) |
| clk_cpu | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset, held across both clocks |
| sleep_req | input | 1 | One CPU-cycle sleep command |
| irq_pend | input | NUM_IRQ | Pending interrupt requests |
| irq_mask | input | NUM_IRQ | Per-request block bits, 1 = blocked |
| por_in | input | 1 | Power-on-reset monitor level |
| lvd_in | input | 1 | Low-voltage monitor level |
| pwr_down | output | 1 | System power-down |
| smp_stb | output | 1 | One slow-cycle strobe, monitor levels just latched |
| por_lat | output | 1 | Latched power-on-reset level |
| lvd_lat | output | 1 | Latched low-voltage level |
| bus_req | output | 1 | Bus request toward the CPU (slow falling-edge flop) |
| bus_ack | output | 1 | CPU-side bus acknowledge |
| asleep | output | 1 | Sequencer is outside the awake state |

## Verification
The bench drives a wakeup request 30 ns after a slow rising edge. From there the results fall at fixed offsets. pwr_down is still high after both falling-edge samples and low after the next rising edge. The strobe and latched levels appear one rising edge later. bus_req is low at the falling edge after that, and bus_ack is low by the same sample point. asleep reads 1 one and two rising edges further on and 0 on the third. Every check samples 30 ns after the edge it targets, a point that never coincides with an edge of either clock. Sleep entry crosses two synchronizers of unknown phase, so it is checked as an ordering within a bounded wait rather than at an exact cycle.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int SYNC_DEPTH = 2;

    typedef enum logic [2:0] {
        ST_AWAKE,
        ST_REQ,
        ST_SLEEP,
        ST_PWRUP,
        ST_SAMPLE,
        ST_RELEASE
    } wake_state_e;

    typedef struct packed {
        logic por;
        logic lvd;
    } mon_t;

    // States in which the sequencer keeps the bus requested
    function automatic logic holds_bus(input wake_state_e s);
        return (s == ST_REQ) || (s == ST_SLEEP) || (s == ST_PWRUP);
    endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int STAGES = 2,
    parameter bit FALL   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (FALL) begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wake_cpu_port.sv
module wake_cpu_port
    import wake_pkg::*;
(
    input  logic clk_cpu,
    input  logic rst,
    input  logic sleep_req,
    input  logic brq,
    output logic sleep_flag,
    output logic bra
);
    logic brq_s;

    wake_sync #(.STAGES(SYNC_DEPTH), .FALL(1'b0)) u_brq_sync (
        .clk (clk_cpu),
        .rst (rst),
        .d   (brq),
        .q   (brq_s)
    );

    always_ff @(posedge clk_cpu) begin
        if (rst) begin
            bra        <= 1'b0;
            sleep_flag <= 1'b0;
        end else begin
            bra        <= brq_s;
            // command held as a level until the bus is granted
            sleep_flag <= (sleep_flag | sleep_req) & ~bra;
        end
    end
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import wake_pkg::*;
(
    input  logic clk_slow,
    input  logic rst,
    input  logic sleep_s,
    input  logic bra_s,
    input  logic wake_s,
    input  mon_t mon_in,
    output logic pwr_down,
    output logic stb,
    output mon_t mon_lat,
    output logic brq,
    output logic asleep
);
    wake_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_AWAKE:   if (sleep_s) nxt = ST_REQ;
            ST_REQ:     if (bra_s)   nxt = ST_SLEEP;
            ST_SLEEP:   if (wake_s)  nxt = ST_PWRUP;
            ST_PWRUP:   nxt = ST_SAMPLE;
            ST_SAMPLE:  nxt = ST_RELEASE;
            ST_RELEASE: if (!bra_s && !sleep_s) nxt = ST_AWAKE;
            default:    nxt = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk_slow) begin
        if (rst) begin
            state    <= ST_AWAKE;
            pwr_down <= 1'b0;
            stb      <= 1'b0;
            mon_lat  <= '0;
        end else begin
            state    <= nxt;
            pwr_down <= (nxt == ST_SLEEP);
            stb      <= (nxt == ST_SAMPLE);
            if (state == ST_PWRUP) mon_lat <= mon_in;
        end
    end

    // bus request changes only on falling edges of the slow clock
    always_ff @(negedge clk_slow) begin
        if (rst) brq <= 1'b0;
        else     brq <= holds_bus(state);
    end

    assign asleep = (state != ST_AWAKE);
endmodule

// File: rtl/wake_seq_top.sv
module wake_seq_top
    import wake_pkg::*;
#(
    parameter int NUM_IRQ = 3
) (
    input  logic               clk_slow,
    input  logic               clk_cpu,
    input  logic               rst,
    input  logic               sleep_req,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               por_in,
    input  logic               lvd_in,
    output logic               pwr_down,
    output logic               smp_stb,
    output logic               por_lat,
    output logic               lvd_lat,
    output logic               bus_req,
    output logic               bus_ack,
    output logic               asleep
);
    logic wake_any, wake_s, sleep_flag, sleep_s, bra_s;
    mon_t mon_in, mon_q;

    assign wake_any = |(irq_pend & ~irq_mask);
    assign mon_in   = '{por: por_in, lvd: lvd_in};

    wake_sync #(.STAGES(SYNC_DEPTH), .FALL(1'b1)) u_irq_sync (
        .clk (clk_slow), .rst (rst), .d (wake_any), .q (wake_s)
    );

    wake_sync #(.STAGES(SYNC_DEPTH), .FALL(1'b0)) u_sleep_sync (
        .clk (clk_slow), .rst (rst), .d (sleep_flag), .q (sleep_s)
    );

    wake_sync #(.STAGES(SYNC_DEPTH), .FALL(1'b0)) u_ack_sync (
        .clk (clk_slow), .rst (rst), .d (bus_ack), .q (bra_s)
    );

    wake_cpu_port u_cpu (
        .clk_cpu    (clk_cpu),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .brq        (bus_req),
        .sleep_flag (sleep_flag),
        .bra        (bus_ack)
    );

    wake_fsm u_fsm (
        .clk_slow (clk_slow),
        .rst      (rst),
        .sleep_s  (sleep_s),
        .bra_s    (bra_s),
        .wake_s   (wake_s),
        .mon_in   (mon_in),
        .pwr_down (pwr_down),
        .stb      (smp_stb),
        .mon_lat  (mon_q),
        .brq      (bus_req),
        .asleep   (asleep)
    );

    assign por_lat = mon_q.por;
    assign lvd_lat = mon_q.lvd;
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk (
    input logic clk_slow,
    input logic clk_cpu,
    input logic rst,
    input logic pwr_down,
    input logic smp_stb,
    input logic por_lat,
    input logic lvd_lat,
    input logic bus_req,
    input logic bus_ack,
    input logic asleep
);
    AST_PD_NEEDS_ACK: assert property (@(posedge clk_slow) disable iff (rst)
        pwr_down |-> bus_ack); // R2

    AST_ACK_AFTER_REQ: assert property (@(posedge clk_cpu) disable iff (rst)
        $rose(bus_ack) |-> bus_req); // R2

    AST_STB_AFTER_PD: assert property (@(posedge clk_slow) disable iff (rst)
        $fell(pwr_down) |=> smp_stb); // R5

    AST_STB_SINGLE: assert property (@(posedge clk_slow) disable iff (rst)
        smp_stb |=> !smp_stb); // R6

    AST_REQ_DROP_AFTER_SAMPLE: assert property (@(posedge clk_slow) disable iff (rst)
        $fell(bus_req) |-> smp_stb); // R7

    AST_ACK_DROP_AFTER_REQ: assert property (@(posedge clk_cpu) disable iff (rst)
        $fell(bus_ack) |-> !bus_req); // R8

    AST_AWAKE_QUIET: assert property (@(posedge clk_slow) disable iff (rst)
        !asleep |-> (!bus_req && !pwr_down && !smp_stb)); // R9

    AST_LATCH_HOLD: assert property (@(posedge clk_slow) disable iff (rst)
        !smp_stb |-> $stable({por_lat, lvd_lat})); // R10
endmodule

bind wake_seq_top wake_seq_chk u_wake_chk (
    .clk_slow (clk_slow),
    .clk_cpu  (clk_cpu),
    .rst      (rst),
    .pwr_down (pwr_down),
    .smp_stb  (smp_stb),
    .por_lat  (por_lat),
    .lvd_lat  (lvd_lat),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .asleep   (asleep)
);

// File: tb/wake_seq_top_tb_top.sv
module wake_seq_top_tb_top;
    localparam int NI = 3;

    logic          clk_slow = 1'b0;
    logic          clk_cpu  = 1'b0;
    logic          rst      = 1'b1;
    logic          sleep_req = 1'b0;
    logic [NI-1:0] irq_pend = '0;
    logic [NI-1:0] irq_mask = '0;
    logic          por_in = 1'b0;
    logic          lvd_in = 1'b0;
    logic pwr_down, smp_stb, por_lat, lvd_lat, bus_req, bus_ack, asleep;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4  clk_cpu  = ~clk_cpu;   // 125 MHz
    always #64 clk_slow = ~clk_slow;  // slow sequencing clock

    wake_seq_top #(.NUM_IRQ(NI)) dut_i (
        .clk_slow (clk_slow), .clk_cpu (clk_cpu), .rst (rst),
        .sleep_req (sleep_req), .irq_pend (irq_pend), .irq_mask (irq_mask),
        .por_in (por_in), .lvd_in (lvd_in),
        .pwr_down (pwr_down), .smp_stb (smp_stb),
        .por_lat (por_lat), .lvd_lat (lvd_lat),
        .bus_req (bus_req), .bus_ack (bus_ack), .asleep (asleep)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // sample points 30 ns after a slow edge never meet an edge of either clock
    task automatic wp();
        @(posedge clk_slow); #30;
    endtask
    task automatic wn();
        @(negedge clk_slow); #30;
    endtask

    task automatic enter_sleep();
        bit seen_asleep = 1'b0;
        bit reached = 1'b0;
        sleep_req = 1'b1;
        #8;
        sleep_req = 1'b0;
        for (int i = 0; i < 30 && !reached; i++) begin
            wp();
            if (asleep && !seen_asleep) begin
                seen_asleep = 1'b1;
                chk("R2", "pd when asleep first seen", pwr_down, 1'b0);
            end
            if (pwr_down) begin
                reached = 1'b1;
                chk("R2", "ack at power-down", bus_ack, 1'b1);
                chk("R2", "req at power-down", bus_req, 1'b1);
                chk("R2", "asleep at power-down", asleep, 1'b1);
            end
        end
        chk("R2", "power-down reached", reached, 1'b1);
    endtask

    // called right after wp(); request driven now
    task automatic wake(input logic [NI-1:0] pend, input logic [NI-1:0] mask,
                        input logic p, input logic l);
        por_in = p; lvd_in = l;
        irq_pend = pend; irq_mask = mask;
        wn(); chk("R5", "pd after first sample", pwr_down, 1'b1);
        wn(); chk("R5", "pd after second sample", pwr_down, 1'b1);
        wp(); chk("R5", "pd released", pwr_down, 1'b0);
              chk("R6", "no strobe yet", smp_stb, 1'b0);
              chk("R7", "req held at release", bus_req, 1'b1);
              chk("R3", "wake started", asleep, 1'b1);
        wp(); chk("R6", "strobe", smp_stb, 1'b1);
              chk("R6", "por latched", por_lat, p);
              chk("R6", "lvd latched", lvd_lat, l);
              chk("R7", "req held at sample", bus_req, 1'b1);
        // inputs change after sampling: latch must hold (R10)
        por_in = ~p; lvd_in = ~l;
        wn(); chk("R7", "req dropped", bus_req, 1'b0);
              chk("R8", "ack dropped", bus_ack, 1'b0);
        wp(); chk("R6", "strobe one cycle", smp_stb, 1'b0);
              chk("R8", "asleep during handoff", asleep, 1'b1);
        wp(); chk("R8", "asleep one edge later", asleep, 1'b1);
        wp(); chk("R8", "awake", asleep, 1'b0);
              chk("R10", "por held", por_lat, p);
              chk("R10", "lvd held", lvd_lat, l);
        irq_pend = '0; irq_mask = '0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic p0, l0;
        repeat (3) wp();
        chk("R1", "pd in reset", pwr_down, 1'b0);
        chk("R1", "req in reset", bus_req, 1'b0);
        chk("R1", "ack in reset", bus_ack, 1'b0);
        chk("R1", "asleep in reset", asleep, 1'b0);
        chk("R1", "stb in reset", smp_stb, 1'b0);
        chk("R1", "por_lat in reset", por_lat, 1'b0);
        chk("R1", "lvd_lat in reset", lvd_lat, 1'b0);
        rst = 1'b0;
        wp();
        chk("R1", "pd after reset", pwr_down, 1'b0);
        chk("R1", "asleep after reset", asleep, 1'b0);

        // R9: unmasked requests while awake do nothing
        irq_pend = '1; irq_mask = '0;
        for (int i = 0; i < 6; i++) begin
            wp();
            chk("R9", "asleep", asleep, 1'b0);
            chk("R9", "pd", pwr_down, 1'b0);
            chk("R9", "req", bus_req, 1'b0);
            chk("R9", "stb", smp_stb, 1'b0);
        end
        irq_pend = '0;
        wp();

        // R3/R6: each single request bit, every monitor pattern
        for (int b = 0; b < NI; b++) begin
            for (int m = 0; m < 4; m++) begin
                logic [NI-1:0] pend;
                logic [NI-1:0] mask;
                pend = NI'(1) << b;
                mask = ~pend & NI'(m * 3);
                enter_sleep();
                wp();
                wake(pend, mask, m[1], m[0]);
                wp();
            end
        end

        // R4/R10: every fully masked pattern while asleep
        p0 = por_lat; l0 = lvd_lat;
        enter_sleep();
        for (int pd_i = 1; pd_i < (1 << NI); pd_i++) begin
            for (int mk = 0; mk < (1 << NI); mk++) begin
                if ((pd_i & ~mk & ((1 << NI) - 1)) == 0) begin
                    irq_pend = NI'(pd_i); irq_mask = NI'(mk);
                    por_in = ~por_in; lvd_in = ~lvd_in;
                    repeat (3) wp();
                    chk("R4", "pd held under mask", pwr_down, 1'b1);
                    chk("R4", "req held under mask", bus_req, 1'b1);
                    chk("R10", "por_lat held asleep", por_lat, p0);
                    chk("R10", "lvd_lat held asleep", lvd_lat, l0);
                end
            end
        end
        irq_pend = '0; irq_mask = '0;
        wp();
        // multi-bit unmasked request ends the masked phase
        wake({NI{1'b1}}, {1'b1, {(NI-1){1'b0}}}, 1'b1, 1'b1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule